// File: doc/BRIEF.md
# Sector Write-Lock Gate

This block sits between the byte-level front end of a serial memory and its storage array. For every byte access it decides whether the array, or the protection storage beside it, may be touched. Protection works on fixed 128-byte sectors. Each sector has one lock bit, and the 64 bits together form a lock vector that the block holds in its own registers.

A select input splits the address space into two parts. With the select low, the address points into user memory. With the select high, it points into a system space. That space holds the per-sector status bytes at the bottom of its range and the lock vector in an eight-byte window starting at byte 2048.

A session flag, driven by the password checker upstream, opens everything while it is set:
- every user sector accepts writes;
- the lock vector can be rewritten;
- the status bytes can be rewritten.

When the flag drops, the block goes back to gating writes with whatever lock bits were last stored. Every decision is combinational on the request cycle. A write to the lock vector is visible from the next cycle on.

Top module: `sector_wlock_gate`

## Requirements
- R1: After reset, every lock bit is 0, and each of the eight lock bytes reads back as 8'h00.
- R2: The sector of a user address is address bits 12:7. Lock byte k, at system address 2048+k, holds in its bit j the lock of sector 8k+j.
- R3: A user write to a sector whose lock bit is 1 while `unlocked` is 0 leaves `mem_we` low and raises `wr_reject` in the same cycle.
- R4: A user write to a sector whose lock bit is 0 raises `mem_we` in the same cycle, with `wr_reject` low.
- R5: While `unlocked` is 1, a user write to any sector raises `mem_we`, whatever its lock bit.
- R6: A user read (`rd_req` with `sys_sel` 0) always raises `mem_re`, whatever the lock bits and the `unlocked` flag.
- R7: A write to a lock byte while `unlocked` is 1 stores `wr_data` into that byte, and the new value takes effect from the next cycle. The same write while `unlocked` is 0 raises `wr_reject` and leaves the byte unchanged.
- R8: A system address below 64 is the status-byte area. A read there always raises `stat_re`. A write there raises `stat_we` only while `unlocked` is 1, and otherwise raises `wr_reject`.
- R9: A read of a lock byte raises `lock_rvalid` and presents the byte on `lock_rdata` in the same cycle, whatever the state of `unlocked`. When `lock_rvalid` is low, `lock_rdata` is 8'h00.
- R10: A system address in neither window gives no enable: a write there raises `wr_reject`, and a read raises nothing.
- R11: When `wr_req` and `rd_req` are both high, the read is ignored: `mem_re`, `stat_re` and `lock_rvalid` stay low. At most one of the six outputs `mem_we`, `mem_re`, `stat_we`, `stat_re`, `lock_rvalid` and `wr_reject` is high in any cycle.
- R12: Once `unlocked` falls, user writes are gated by the lock bits most recently written, including bits that were set or cleared during the unlocked session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lock vector |
| addr | input | 13 | Byte address of the access |
| sys_sel | input | 1 | 0 selects user memory, 1 selects the system space |
| wr_req | input | 1 | Byte write request |
| rd_req | input | 1 | Byte read request |
| wr_data | input | 8 | Write data, stored when a lock byte is written |
| unlocked | input | 1 | Session flag set by a correct password |
| mem_we | output | 1 | Write strobe to the user array |
| mem_re | output | 1 | Read strobe to the user array |
| stat_we | output | 1 | Write strobe to the status-byte area |
| stat_re | output | 1 | Read strobe to the status-byte area |
| lock_rvalid | output | 1 | A lock byte is being read |
| lock_rdata | output | 8 | Lock byte read data |
| wr_reject | output | 1 | The write of this cycle was refused |

## Verification
The bench builds the block with its default parameters: 64 sectors of 128 bytes, the lock window at system byte 2048, and 64 status bytes. With these values the top sector (addresses up to 8191) and the highest lock byte (2055) are both reachable, and so is the first address past each window. A loop writes several lock patterns across all eight lock bytes and then tries a write to every one of the 64 sectors. This exercises every lock bit against its own sector.

// File: rtl/swg_pkg.sv
package swg_pkg;

    typedef enum logic [1:0] {
        RG_USER = 2'd0,
        RG_STAT = 2'd1,
        RG_LOCK = 2'd2,
        RG_NONE = 2'd3
    } region_e;

endpackage

// File: rtl/swg_decode.sv
module swg_decode
    import swg_pkg::*;
#(
    parameter int SECT_NUM   = 64,
    parameter int SECT_BYTES = 128,
    parameter int LOCK_BASE  = 2048,
    parameter int STAT_BYTES = 64,
    parameter int ADDR_W     = $clog2(SECT_NUM) + $clog2(SECT_BYTES)
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            sys_sel,
    output region_e                         region,
    output logic [$clog2(SECT_NUM)-1:0]     sect_idx,
    output logic [$clog2(SECT_NUM/8)-1:0]   lock_idx
);
    localparam int SECT_W     = $clog2(SECT_NUM);
    localparam int OFF_W      = $clog2(SECT_BYTES);
    localparam int LOCK_BYTES = SECT_NUM / 8;
    localparam int LB_W       = $clog2(LOCK_BYTES);

    logic [31:0] a32;
    logic [31:0] lock_off;

    always_comb begin
        a32      = {{(32-ADDR_W){1'b0}}, addr};
        lock_off = a32 - 32'(LOCK_BASE);
        sect_idx = addr[OFF_W +: SECT_W];
        lock_idx = lock_off[LB_W-1:0];
        if (!sys_sel) begin
            region = RG_USER;
        end else if (a32 < 32'(STAT_BYTES)) begin
            region = RG_STAT;
        end else if (a32 >= 32'(LOCK_BASE) && a32 < 32'(LOCK_BASE + LOCK_BYTES)) begin
            region = RG_LOCK;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/swg_lock_store.sv
module swg_lock_store #(
    parameter int SECT_NUM = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(SECT_NUM/8)-1:0]    byte_idx,
    input  logic [7:0]                       wr_byte,
    input  logic [$clog2(SECT_NUM)-1:0]      sect_idx,
    output logic [7:0]                       rd_byte,
    output logic                             sect_locked
);
    localparam int LOCK_BYTES = SECT_NUM / 8;

    typedef struct packed {
        logic [SECT_NUM-1:0] vec;
    } lock_st_t;

    lock_st_t st_d;
    lock_st_t st_q;
    logic [SECT_NUM-1:0] vec_next;

    for (genvar g = 0; g < LOCK_BYTES; g++) begin : g_byte
        always_comb begin
            if (wr_en && (32'(byte_idx) == g)) begin
                vec_next[g*8 +: 8] = wr_byte;
            end else begin
                vec_next[g*8 +: 8] = st_q.vec[g*8 +: 8];
            end
        end
    end

    always_comb begin
        st_d.vec    = vec_next;
        rd_byte     = st_q.vec[byte_idx*8 +: 8];
        sect_locked = st_q.vec[sect_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the vector moves only on an enabled byte write
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.vec));

    // R7: an enabled write lands in the addressed byte
    a_r7_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vec[$past(byte_idx)*8 +: 8] == $past(wr_byte)));

endmodule

// File: rtl/sector_wlock_gate.sv
module sector_wlock_gate
    import swg_pkg::*;
#(
    parameter int SECT_NUM   = 64,
    parameter int SECT_BYTES = 128,
    parameter int LOCK_BASE  = 2048,
    parameter int STAT_BYTES = 64,
    parameter int ADDR_W     = $clog2(SECT_NUM) + $clog2(SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sys_sel,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [7:0]        wr_data,
    input  logic              unlocked,
    output logic              mem_we,
    output logic              mem_re,
    output logic              stat_we,
    output logic              stat_re,
    output logic              lock_rvalid,
    output logic [7:0]        lock_rdata,
    output logic              wr_reject
);
    localparam int SECT_W = $clog2(SECT_NUM);
    localparam int LB_W   = $clog2(SECT_NUM / 8);

    region_e           region;
    logic [SECT_W-1:0] sect_idx;
    logic [LB_W-1:0]   lock_idx;
    logic [7:0]        lock_byte;
    logic              sect_locked;
    logic              lock_we;
    logic              rd_only;

    swg_decode #(
        .SECT_NUM   (SECT_NUM),
        .SECT_BYTES (SECT_BYTES),
        .LOCK_BASE  (LOCK_BASE),
        .STAT_BYTES (STAT_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr     (addr),
        .sys_sel  (sys_sel),
        .region   (region),
        .sect_idx (sect_idx),
        .lock_idx (lock_idx)
    );

    swg_lock_store #(
        .SECT_NUM (SECT_NUM)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (lock_we),
        .byte_idx    (lock_idx),
        .wr_byte     (wr_data),
        .sect_idx    (sect_idx),
        .rd_byte     (lock_byte),
        .sect_locked (sect_locked)
    );

    always_comb begin
        rd_only     = rd_req && !wr_req;
        mem_we      = wr_req && (region == RG_USER) && (unlocked || !sect_locked);
        stat_we     = wr_req && (region == RG_STAT) && unlocked;
        lock_we     = wr_req && (region == RG_LOCK) && unlocked;
        wr_reject   = wr_req && !(mem_we || stat_we || lock_we);
        mem_re      = rd_only && (region == RG_USER);
        stat_re     = rd_only && (region == RG_STAT);
        lock_rvalid = rd_only && (region == RG_LOCK);
        lock_rdata  = lock_rvalid ? lock_byte : 8'h00;
    end

    // R3: a refused write never reaches any store
    a_r3_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> !(mem_we || stat_we));

    // R11: the outputs never overlap
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re, stat_we, stat_re, lock_rvalid, wr_reject}));

    // R6: the array read strobe belongs to user space only
    a_r6_user_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (!sys_sel && rd_req));

endmodule

// File: tb/sector_wlock_gate_test.sv
module sector_wlock_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        sys_sel = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        unlocked = 1'b0;
    logic        mem_we, mem_re, stat_we, stat_re, lock_rvalid, wr_reject;
    logic [7:0]  lock_rdata;

    int total = 0;
    int bad = 0;
    bit model_lock [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_wlock_gate uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sys_sel(sys_sel),
        .wr_req(wr_req), .rd_req(rd_req), .wr_data(wr_data), .unlocked(unlocked),
        .mem_we(mem_we), .mem_re(mem_re), .stat_we(stat_we), .stat_re(stat_re),
        .lock_rvalid(lock_rvalid), .lock_rdata(lock_rdata), .wr_reject(wr_reject)
    );

    task automatic cmp(string tag, string name, int act, int exp);
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
        end
    endtask

    task automatic step(string tag, int a, bit s, bit w, bit r, int d, bit u);
        int  e_mwe, e_mre, e_swe, e_sre, e_lrv, e_lrd, e_rej;
        bit  is_lock, is_stat, lock_ok;
        int  k;
        @(negedge clk);
        addr = 13'(a); sys_sel = s; wr_req = w; rd_req = r;
        wr_data = 8'(d); unlocked = u;
        #1;
        is_lock = s && a >= 2048 && a < 2056;
        is_stat = s && a < 64;
        e_mwe = (w && !s && (u || !model_lock[a / 128])) ? 1 : 0;
        e_swe = (w && is_stat && u) ? 1 : 0;
        lock_ok = w && is_lock && u;
        e_rej = (w && !(e_mwe == 1 || e_swe == 1 || lock_ok)) ? 1 : 0;
        e_mre = (!w && r && !s) ? 1 : 0;
        e_sre = (!w && r && is_stat) ? 1 : 0;
        e_lrv = (!w && r && is_lock) ? 1 : 0;
        e_lrd = 0;
        if (e_lrv == 1) begin
            k = a - 2048;
            for (int j = 0; j < 8; j++) e_lrd += model_lock[k*8 + j] << j;
        end
        total++;
        cmp(tag, "mem_we", mem_we, e_mwe);
        cmp(tag, "mem_re", mem_re, e_mre);
        cmp(tag, "stat_we", stat_we, e_swe);
        cmp(tag, "stat_re", stat_re, e_sre);
        cmp(tag, "lock_rvalid", lock_rvalid, e_lrv);
        cmp(tag, "lock_rdata", lock_rdata, e_lrd);
        cmp(tag, "wr_reject", wr_reject, e_rej);
        if (lock_ok) begin
            k = a - 2048;
            for (int j = 0; j < 8; j++) model_lock[k*8 + j] = d[j];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model_lock[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state read back
        for (int k = 0; k < 8; k++) step("R1", 2048 + k, 1, 0, 1, 0, 0);
        // R4 open sectors
        step("R4", 0, 0, 1, 0, 8'h11, 0);
        step("R4", 8191, 0, 1, 0, 8'h22, 0);
        // R7 lock write refused while locked
        step("R7", 2048, 1, 1, 0, 8'h06, 0);
        step("R7", 2048, 1, 0, 1, 0, 0);
        // R7 and R2 lock write accepted
        step("R7", 2048, 1, 1, 0, 8'h06, 1);
        step("R2", 2055, 1, 1, 0, 8'hC0, 1);
        step("R9", 2048, 1, 0, 1, 0, 1);
        step("R9", 2055, 1, 0, 1, 0, 0);
        // R3 and R2 gating by sector
        step("R3", 128, 0, 1, 0, 0, 0);
        step("R3", 300, 0, 1, 0, 0, 0);
        step("R3", 8191, 0, 1, 0, 0, 0);
        step("R3", 62*128, 0, 1, 0, 0, 0);
        step("R2", 127, 0, 1, 0, 0, 0);
        step("R2", 61*128 + 127, 0, 1, 0, 0, 0);
        step("R2", 384, 0, 1, 0, 0, 0);
        // R5 open session
        step("R5", 128, 0, 1, 0, 0, 1);
        step("R5", 8191, 0, 1, 0, 0, 1);
        // R6 reads of locked sectors
        step("R6", 128, 0, 0, 1, 0, 0);
        step("R6", 8000, 0, 0, 1, 0, 1);
        // R8 status area
        step("R8", 0, 1, 0, 1, 0, 0);
        step("R8", 63, 1, 1, 0, 0, 0);
        step("R8", 63, 1, 1, 0, 0, 1);
        // R10 holes in system space
        step("R10", 64, 1, 1, 0, 0, 1);
        step("R10", 2047, 1, 0, 1, 0, 1);
        step("R10", 2056, 1, 1, 0, 8'hFF, 1);
        step("R10", 2056, 1, 0, 1, 0, 0);
        // R11 simultaneous requests
        step("R11", 0, 0, 1, 1, 0, 0);
        step("R11", 2048, 1, 1, 1, 8'h04, 1);
        step("R11", 10, 1, 1, 1, 0, 0);
        // R12 updated bits govern after the session
        step("R12", 128, 0, 1, 0, 0, 0);
        step("R12", 256, 0, 1, 0, 0, 0);
        // R2 sweep of patterns over every sector
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 8; k++)
                step("R7", 2048 + k, 1, 1, 0, (k * 37 + p * 91 + 5) & 8'hFF, 1);
            for (int sct = 0; sct < 64; sct++)
                step("R2", sct * 128 + (sct % 128), 0, 1, 0, 0, 0);
            for (int k = 0; k < 8; k++) step("R9", 2048 + k, 1, 0, 1, 0, 0);
        end
        // R1 reset clears the vector again
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) model_lock[i] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) step("R1", 2048 + k, 1, 0, 1, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule